// File: doc/BRIEF.md
# Interrupt-Capable GPIO Pin Bank

The block controls 32 general-purpose pins, arranged as four ports of eight pins, behind a single-cycle register bus. For each pin, software can claim it for GPIO use, choose whether the pad is driven, and set the value driven. It can also read back the pad level after synchronization. Every pin can raise an interrupt. The trigger type is chosen per pin from five options: high level, low level, rising edge, falling edge and either edge. Detected events are latched in per-pin status bits. A status bit that is set while its enable bit is set drives the single bank interrupt line.

Bus addresses are byte addresses. Bits 1:0 are ignored. Bits 3:2 pick the port and bits 6:4 pick the register group. A second copy of the map starts at 0x80. A write there changes only the pins whose bits are set in the upper byte of the write data. Software can therefore change one pin without a read-modify-write sequence. The trigger type of each pin is stored as three bits, spread over three bytes of the trigger register: polarity, edge mode and either-edge.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` and `pad_out` are zero and `bank_irq` is low.
- R2: Direct registers sit at byte address group*0x10 + port*4. The groups are: 0 pin enable, 1 drive enable, 2 drive value, 4 status, 5 interrupt enable, 6 trigger type (24 bits) and 7 clear. A direct write to group 0, 1, 2, 4 or 5 loads bits 7:0 of the write data. A direct write to group 6 loads bits 23:0. A read of groups 0 to 6 returns the register in the low bits of the read data.
- R3: Address 0x80 plus a direct address is a masked alias of groups 0, 1, 2, 4, 5 and 6. In a write to an alias, write bits 15:8 select the pins to change and bits 7:0 give their new values. Pins that are not selected keep their old values. An alias write to group 6 changes only the polarity byte (bits 7:0). A read of an alias returns the same value as a read of the direct register.
- R4: Pin n drives `pad_oe[n]` = pin enable AND drive enable. It drives `pad_out[n]` from its drive value bit.
- R5: Group 3 (input) returns the pad value after a two-flop synchronizer. A pad change made between clock edges appears in a read after the second rising edge, not after the first.
- R6: In the trigger register of a port, bit p is the polarity of pin p (1 means high or rising), bit 8+p selects edge mode and bit 16+p selects either-edge. With the edge-mode bit at 0, the status bit is set on every cycle that the synchronized input equals the polarity bit. The status bit therefore cannot stay cleared while that level lasts.
- R7: With the edge-mode bit at 1 and the either-edge bit at 0, the status bit is set only on a rising edge (polarity 1) or only on a falling edge (polarity 0). A steady level sets nothing.
- R8: With the edge-mode bit at 1 and the either-edge bit at 1, any change of the synchronized input sets the status bit.
- R9: A direct write to group 7 clears each status bit whose write bit is 1. A write bit of 0 leaves the status bit unchanged. An event in the same cycle as a clear wins, and the status bit stays set.
- R10: `bank_irq` is high exactly when some status bit of any port is set while its interrupt enable bit is set.
- R11: Reads of unmapped addresses return zero, and writes to them change nothing. Unmapped addresses are all addresses at 0x100 or above, plus the alias addresses of groups 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, takes effect on the next rising edge |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, valid in the same cycle |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| bank_irq | output | 1 | Bank interrupt, level |

## Verification
The assertions check the following on every cycle:
- any detected event appears in the status register on the next edge;
- a status bit being cleared never loses a concurrent event;
- the interrupt stays low while no pin is enabled;
- unmapped reads return zero;
- pad drive enables change only after a bus write.

Some behaviour is visible only in directed bench scenarios:
- which input patterns count as events for each trigger type;
- that a level trigger sets its status bit again right after a clear;
- the two-edge latency of the synchronizer;
- that alias writes leave unselected pins unchanged.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

    localparam int PORT_CNT     = 4;
    localparam int PIN_PER_PORT = 8;
    localparam int PIN_CNT      = PORT_CNT * PIN_PER_PORT;
    localparam int MAP_SPAN     = 256;

    typedef enum logic [2:0] {
        GRP_CFG = 3'd0,
        GRP_OE  = 3'd1,
        GRP_OUT = 3'd2,
        GRP_IN  = 3'd3,
        GRP_STA = 3'd4,
        GRP_IEN = 3'd5,
        GRP_LVL = 3'd6,
        GRP_CLR = 3'd7
    } grp_e;

    // Trigger type of one port: most significant byte first.
    typedef struct packed {
        logic [PIN_PER_PORT-1:0] both;
        logic [PIN_PER_PORT-1:0] edg;
        logic [PIN_PER_PORT-1:0] pol;
    } lvl_t;

    typedef struct packed {
        logic       mapped;
        logic       is_alias;
        grp_e       grp;
        logic [1:0] port;
    } dec_t;

    function automatic dec_t decode_addr(input logic [31:0] a);
        dec_t d;
        d.is_alias = a[7];
        d.grp      = grp_e'(a[6:4]);
        d.port     = a[3:2];
        d.mapped   = (a[31:8] == 24'd0) &&
                     !(a[7] && (d.grp == GRP_IN || d.grp == GRP_CLR));
        return d;
    endfunction

    // Upper byte selects pins, lower byte carries their values.
    function automatic logic [7:0] merge_masked(input logic [7:0] old,
                                                input logic [15:0] w);
        return (old & ~w[15:8]) | (w[7:0] & w[15:8]);
    endfunction

    function automatic logic pin_event(input logic pol, input logic edg,
                                       input logic both, input logic cur,
                                       input logic prv);
        if (!edg) return cur == pol;
        if (both) return cur != prv;
        if (pol)  return cur & ~prv;
        return ~cur & prv;
    endfunction

endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            old_q  <= '0;
        end else begin
            meta_q <= pad;
            stab_q <= meta_q;
            old_q  <= stab_q;
        end
    end

    assign cur = stab_q;
    assign prv = old_q;
endmodule

// File: rtl/pbk_port.sv
module pbk_port
    import pbk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    is_alias,
    input  grp_e                    grp,
    input  logic [23:0]             wdata,
    input  logic [PIN_PER_PORT-1:0] cur,
    input  logic [PIN_PER_PORT-1:0] prv,
    output logic [PIN_PER_PORT-1:0] cfg,
    output logic [PIN_PER_PORT-1:0] oe,
    output logic [PIN_PER_PORT-1:0] dout,
    output logic [PIN_PER_PORT-1:0] ien,
    output logic [PIN_PER_PORT-1:0] sta,
    output logic [PIN_PER_PORT-1:0] hit,
    output lvl_t                    lvl
);
    logic [PIN_PER_PORT-1:0] sta_nx;

    function automatic logic [7:0] wnext(input logic [7:0] old);
        return is_alias ? merge_masked(old, wdata[15:0]) : wdata[7:0];
    endfunction

    for (genvar b = 0; b < PIN_PER_PORT; b++) begin : g_pin
        assign hit[b] = pin_event(lvl.pol[b], lvl.edg[b], lvl.both[b],
                                  cur[b], prv[b]);
    end

    always_comb begin
        sta_nx = sta;
        if (wr_en && grp == GRP_STA)
            sta_nx = wnext(sta);
        if (wr_en && grp == GRP_CLR && !is_alias)
            sta_nx = sta_nx & ~wdata[7:0];
        sta_nx = sta_nx | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            oe   <= '0;
            dout <= '0;
            ien  <= '0;
            sta  <= '0;
            lvl  <= '0;
        end else begin
            if (wr_en && grp == GRP_CFG) cfg  <= wnext(cfg);
            if (wr_en && grp == GRP_OE)  oe   <= wnext(oe);
            if (wr_en && grp == GRP_OUT) dout <= wnext(dout);
            if (wr_en && grp == GRP_IEN) ien  <= wnext(ien);
            if (wr_en && grp == GRP_LVL) begin
                if (is_alias) lvl.pol <= wnext(lvl.pol);
                else          lvl     <= lvl_t'(wdata);
            end
            sta <= sta_nx;
        end
    end
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
    import pbk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe,
    output logic              bank_irq
);
    localparam int PB = PIN_PER_PORT;

    dec_t              dec;
    logic [PIN_CNT-1:0] cur_all;
    logic [PIN_CNT-1:0] prv_all;
    logic [PIN_CNT-1:0] sta_all;
    logic [PIN_CNT-1:0] ien_all;
    logic [PIN_CNT-1:0] hit_all;
    logic [PB-1:0]     cfg_a [PORT_CNT];
    logic [PB-1:0]     oe_a  [PORT_CNT];
    logic [PB-1:0]     out_a [PORT_CNT];
    lvl_t              lvl_a [PORT_CNT];
    logic [DATA_W-1:0] rd_d;
    logic              unused_wdata;

    assign dec          = decode_addr(32'(bus_addr));
    assign unused_wdata = ^bus_wdata[DATA_W-1:24];

    pbk_sync #(.W(PIN_CNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .pad (pad_in),
        .cur (cur_all),
        .prv (prv_all)
    );

    for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
        logic wr_p;
        assign wr_p = bus_we && dec.mapped && (dec.port == 2'(p));

        pbk_port u_port (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_p),
            .is_alias (dec.is_alias),
            .grp      (dec.grp),
            .wdata    (bus_wdata[23:0]),
            .cur      (cur_all[p*PB +: PB]),
            .prv      (prv_all[p*PB +: PB]),
            .cfg      (cfg_a[p]),
            .oe       (oe_a[p]),
            .dout     (out_a[p]),
            .ien      (ien_all[p*PB +: PB]),
            .sta      (sta_all[p*PB +: PB]),
            .hit      (hit_all[p*PB +: PB]),
            .lvl      (lvl_a[p])
        );

        assign pad_oe[p*PB +: PB]  = cfg_a[p] & oe_a[p];
        assign pad_out[p*PB +: PB] = out_a[p];
    end

    always_comb begin
        rd_d = '0;
        if (dec.mapped) begin
            case (dec.grp)
                GRP_CFG: rd_d[7:0]  = cfg_a[dec.port];
                GRP_OE:  rd_d[7:0]  = oe_a[dec.port];
                GRP_OUT: rd_d[7:0]  = out_a[dec.port];
                GRP_IN:  rd_d[7:0]  = cur_all[{dec.port, 3'b000} +: PB];
                GRP_STA: rd_d[7:0]  = sta_all[{dec.port, 3'b000} +: PB];
                GRP_IEN: rd_d[7:0]  = ien_all[{dec.port, 3'b000} +: PB];
                GRP_LVL: rd_d[23:0] = lvl_a[dec.port];
                default: rd_d       = '0;
            endcase
        end
    end

    assign bus_rdata = rd_d;
    assign bank_irq  = |(sta_all & ien_all);
endmodule

// File: rtl/pbk_chk.sv
module pbk_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [31:0]       pad_oe,
    input logic              bank_irq,
    input logic [31:0]       sta_all,
    input logic [31:0]       ien_all,
    input logic [31:0]       hit_all
);
    logic up;

    always_ff @(posedge clk) begin
        if (rst) up <= 1'b0;
        else     up <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_irq == 1'b0 && pad_oe == 32'd0));

    assert_event_latched_R6: assert property (@(posedge clk) disable iff (rst)
        up |-> ((sta_all & $past(hit_all)) == $past(hit_all)));

    assert_oe_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        (up && !$past(bus_we)) |-> $stable(pad_oe));

    assert_no_enable_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (ien_all == 32'd0) |-> !bank_irq);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr >= ADDR_W'(256)) || (bus_addr[7] && bus_addr[5:4] == 2'b11))
        |-> (bus_rdata == '0));

    for (genvar k = 0; k < 4; k++) begin : g_clr
        assert_clear_keeps_event_R9: assert property (@(posedge clk) disable iff (rst)
            (up && $past(bus_we && {bus_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(112 + 4*k)))
            |-> ((sta_all[k*8 +: 8] & $past(bus_wdata[7:0])
                  & ~$past(hit_all[k*8 +: 8])) == 8'd0));
    end
endmodule

bind pin_bank_irq pbk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .bank_irq  (bank_irq),
    .sta_all   (sta_all),
    .ien_all   (ien_all),
    .hit_all   (hit_all)
);

// File: tb/sim_pin_bank_irq.sv
module sim_pin_bank_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        bank_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  armed = 1'b0;
    bit  done  = 1'b0;

    // reference model state
    logic [7:0]  m_cfg [4];
    logic [7:0]  m_oe  [4];
    logic [7:0]  m_out [4];
    logic [7:0]  m_ien [4];
    logic [7:0]  m_sta [4];
    logic [23:0] m_lvl [4];
    logic [31:0] m_s1, m_s2, m_pv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_bank_irq u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .bank_irq  (bank_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        int g, p;
        if (a >= 256) return 32'd0;
        g = (a >> 4) & 7;
        p = (a >> 2) & 3;
        if (a >= 128 && (g == 3 || g == 7)) return 32'd0;
        case (g)
            0: return {24'd0, m_cfg[p]};
            1: return {24'd0, m_oe[p]};
            2: return {24'd0, m_out[p]};
            3: return {24'd0, m_s2[p*8 +: 8]};
            4: return {24'd0, m_sta[p]};
            5: return {24'd0, m_ien[p]};
            6: return {8'd0, m_lvl[p]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] ev;
        int a, g, p;
        logic [7:0] mk, vl;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_cfg[i] = 0; m_oe[i] = 0; m_out[i] = 0;
                m_ien[i] = 0; m_sta[i] = 0; m_lvl[i] = 0;
            end
            m_s1 = 0; m_s2 = 0; m_pv = 0;
            return;
        end
        for (int i = 0; i < 32; i++) begin
            logic po, ed, bo, c, v;
            po = m_lvl[i/8][i%8];
            ed = m_lvl[i/8][8 + i%8];
            bo = m_lvl[i/8][16 + i%8];
            c  = m_s2[i];
            v  = m_pv[i];
            if (!ed)     ev[i] = (c == po);
            else if (bo) ev[i] = (c != v);
            else if (po) ev[i] = c && !v;
            else         ev[i] = !c && v;
        end
        a = int'(bus_addr);
        if (bus_we && a < 256) begin
            g  = (a >> 4) & 7;
            p  = (a >> 2) & 3;
            mk = (a >= 128) ? bus_wdata[15:8] : 8'hFF;
            vl = bus_wdata[7:0];
            if (!(a >= 128 && (g == 3 || g == 7))) begin
                case (g)
                    0: m_cfg[p] = (m_cfg[p] & ~mk) | (vl & mk);
                    1: m_oe[p]  = (m_oe[p]  & ~mk) | (vl & mk);
                    2: m_out[p] = (m_out[p] & ~mk) | (vl & mk);
                    4: m_sta[p] = (m_sta[p] & ~mk) | (vl & mk);
                    5: m_ien[p] = (m_ien[p] & ~mk) | (vl & mk);
                    6: if (a >= 128) m_lvl[p][7:0] = (m_lvl[p][7:0] & ~mk) | (vl & mk);
                       else          m_lvl[p] = bus_wdata[23:0];
                    7: m_sta[p] = m_sta[p] & ~vl;
                    default: ;
                endcase
            end
        end
        for (int i = 0; i < 4; i++) m_sta[i] = m_sta[i] | ev[i*8 +: 8];
        m_pv = m_s2;
        m_s2 = m_s1;
        m_s1 = pad_in;
    endtask

    always @(posedge clk) begin
        logic [31:0] eoe, eout;
        logic        eirq;
        model_step();
        #(CLK_PERIOD/4);
        if (armed && !rst) begin
            eirq = 1'b0;
            for (int i = 0; i < 4; i++) begin
                eoe[i*8 +: 8]  = m_cfg[i] & m_oe[i];
                eout[i*8 +: 8] = m_out[i];
                if ((m_sta[i] & m_ien[i]) != 0) eirq = 1'b1;
            end
            chk("R4 pad_oe per cycle", pad_oe, eoe);
            chk("R4 pad_out per cycle", pad_out, eout);
            chk("R10 bank_irq per cycle", {31'd0, bank_irq}, {31'd0, eirq});
            chk("R2 rdata per cycle", bus_rdata, m_read(int'(bus_addr)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'(a);
        #1 v = bus_rdata;
    endtask

    task automatic setpad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 1'b0;
        armed = 1'b1;

        // R1 reset state
        rd(32'h00, v); chk("R1 cfg after reset", v, 0);
        rd(32'h60, v); chk("R1 trigger after reset", v, 0);
        rd(32'h54, v); chk("R1 enable after reset", v, 0);
        chk("R1 pad_oe after reset", pad_oe, 0);
        chk("R1 irq after reset", {31'd0, bank_irq}, 0);

        // R2 / R4 direct writes on port 1
        wr(32'h04, 32'hFF); wr(32'h14, 32'h0F); wr(32'h24, 32'hA5);
        #1;
        chk("R4 pad_oe port1", pad_oe, 32'h0000_0F00);
        chk("R4 pad_out port1", pad_out, 32'h0000_A500);
        rd(32'h24, v); chk("R2 drive value readback", v, 32'hA5);

        // R3 masked alias
        wr(32'hA4, 32'h0000_F00F);
        rd(32'h24, v); chk("R3 alias keeps unselected pins", v, 32'h05);
        wr(32'h60, 32'h0003_0C);
        wr(32'hE0, 32'h0000_0505);
        rd(32'h60, v); chk("R3 alias trigger polarity only", v, 32'h0003_0D);
        rd(32'hE0, v); chk("R3 alias read mirrors direct", v, 32'h0003_0D);

        // R5 synchronizer latency
        setpad(32'h1234_5678);
        rd(32'h30, v); chk("R5 input after one edge", v, 32'h00);
        rd(32'h30, v); chk("R5 input after two edges", v, 32'h78);
        rd(32'h3C, v); chk("R5 input port3", v, 32'h12);

        // R6 level high on port2 pin0
        setpad(32'h0); tick(4);
        wr(32'h68, 32'h0000_01); wr(32'h58, 32'h01); wr(32'h78, 32'hFF);
        rd(32'h48, v); chk("R6 level high idle", v & 1, 0);
        chk("R10 irq low idle", {31'd0, bank_irq}, 0);
        setpad(32'h0001_0000);
        tick(2); #1 chk("R10 irq not yet", {31'd0, bank_irq}, 0);
        tick(1); #1 chk("R10 irq raised", {31'd0, bank_irq}, 1);
        wr(32'h78, 32'h01);
        rd(32'h48, v); chk("R9 event wins over clear / R6 level persists", v & 1, 1);
        setpad(32'h0); tick(4);
        wr(32'h78, 32'h01);
        rd(32'h48, v); chk("R9 clear after level gone", v & 1, 0);
        #1 chk("R10 irq dropped", {31'd0, bank_irq}, 0);

        // R7 rising on pin1 of port2
        wr(32'h68, 32'h0002_03); wr(32'h78, 32'hFF);
        setpad(32'h0002_0000); tick(4);
        rd(32'h48, v); chk("R7 rising sets", (v >> 1) & 1, 1);
        wr(32'h78, 32'h00);
        rd(32'h48, v); chk("R9 zero clear no effect", (v >> 1) & 1, 1);
        wr(32'h78, 32'h02); tick(2);
        rd(32'h48, v); chk("R7 held level no event", (v >> 1) & 1, 0);

        // R7 falling on pin2
        wr(32'h68, 32'h0006_03);
        setpad(32'h0006_0000); tick(4);
        wr(32'h78, 32'h04);
        rd(32'h48, v); chk("R7 falling ignores rise", (v >> 2) & 1, 0);
        setpad(32'h0002_0000); tick(4);
        rd(32'h48, v); chk("R7 falling sets", (v >> 2) & 1, 1);

        // R8 both edges on pin3
        wr(32'h68, 32'h080E03); wr(32'h78, 32'h08);
        rd(32'h48, v); chk("R8 no change no event", (v >> 3) & 1, 0);
        setpad(32'h000A_0000); tick(4);
        rd(32'h48, v); chk("R8 rise sets", (v >> 3) & 1, 1);
        wr(32'h78, 32'h08);
        rd(32'h48, v); chk("R8 cleared", (v >> 3) & 1, 0);
        setpad(32'h0002_0000); tick(4);
        rd(32'h48, v); chk("R8 fall sets", (v >> 3) & 1, 1);

        // R10 across ports
        wr(32'h58, 32'h00);
        wr(32'hDC, 32'h8080);
        #1 chk("R10 irq from port3", {31'd0, bank_irq}, 1);
        rd(32'h5C, v); chk("R3 alias enable set", v, 32'h80);
        wr(32'hDC, 32'h8000);
        #1 chk("R10 irq after disable", {31'd0, bank_irq}, 0);

        // R11 unmapped
        rd(32'h100, v); chk("R11 read above map", v, 0);
        rd(32'hB4, v);  chk("R11 read input alias", v, 0);
        rd(32'hF8, v);  chk("R11 read clear alias", v, 0);
        wr(32'h104, 32'h0);
        rd(32'h04, v);  chk("R11 write above map ignored", v, 32'hFF);
        wr(32'hF8, 32'hFFFF);
        rd(32'h48, v);  chk("R11 clear alias ignored", (v >> 3) & 1, 1);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_addr  = 12'($urandom_range(0, 319) << 2);
            bus_wdata = $urandom;
            bus_we    = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 7) == 0) pad_in = $urandom;
        end
        @(negedge clk);
        bus_we = 1'b0;
        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule